// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two two's-complement integers of a configurable width using radix-2 Booth recoding, one step per clock. A caller presents the multiplicand and multiplier together with a single-cycle start pulse while the unit is idle. The unit then reports busy while it works through exactly one step per operand bit, and signals completion with a one-cycle done pulse. At that pulse the double-length signed product is available, and it stays there until the next operation completes.

Each step looks at the current low bit of the multiplier register together with a saved copy of the bit seen on the previous step:
- If the two bits are equal, the step only shifts.
- If the current bit is 0 and the saved bit is 1, the multiplicand is added into the upper half of the product.
- If the current bit is 1 and the saved bit is 0, the precomputed negated multiplicand is added into the upper half.

After any addition, the upper and lower halves are shifted right arithmetically as one unit. The multiplier register rotates right rather than draining, so no second copy of the multiplier is needed. The addition uses one guard bit, which keeps the result correct when an operand is the most negative value.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is held, and in the cycle after reset is released, busy is 0, done is 0 and product is all zeros.
- R2: A start pulse seen while busy is 0 is accepted at that clock edge. From the next cycle, busy is 1 for exactly WIDTH consecutive cycles.
- R3: done is 1 for exactly one cycle. That cycle immediately follows the last busy cycle. done and busy are never 1 in the same cycle.
- R4: In the done cycle, product equals the two's-complement product of the accepted operands, as a 2*WIDTH-bit signed value. For example, with WIDTH=4, 2 times -4 gives 8'hF8.
- R5: Operands equal to the most negative value give the correct product. With WIDTH=4: -8 times -8 is 64, -8 times 7 is -56, and 7 times -8 is -56.
- R6: A start pulse or an operand change during a busy cycle has no effect. The run completes on the original schedule with the product of the originally accepted operands.
- R7: product changes only in a done cycle. It holds its value while idle and while a later operation is busy.
- R8: A start pulse in the done cycle is accepted. It begins a new operation with no idle cycle between the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiplication, honoured only when idle |
| mcand | input | WIDTH | Multiplicand, two's complement |
| mplier | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | High while Booth steps are in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Signed double-length result, held between completions |

## Verification
The bench builds the block with WIDTH=4. At this width, all 256 signed operand pairs can be driven exhaustively against a behavioural signed multiply. That sweep reaches every Booth bit-pair sequence and every most-negative-operand combination, including -8 times -8.

Directed runs cover the following:
- Back-to-back starts issued in the done cycle.
- Idle gaps in which the held product is observed.
- Runs where random operands and a second start are injected mid-run and must be ignored.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } booth_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_ADD  = 2'd1,
        ACT_SUB  = 2'd2
    } booth_act_e;

    // Recode the current multiplier bit and the bit from the previous step.
    function automatic booth_act_e booth_decide(input logic cur_bit, input logic prev_bit);
        booth_act_e act;
        case ({cur_bit, prev_bit})
            2'b01:   act = ACT_ADD;
            2'b10:   act = ACT_SUB;
            default: act = ACT_HOLD;
        endcase
        return act;
    endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step_en,
    output logic last_step,
    output logic busy,
    output logic done
);
    import booth_pkg::*;

    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    booth_state_e  state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    assign load      = (state_q == ST_IDLE) && start;
    assign step_en   = (state_q == ST_RUN);
    assign last_step = step_en && (cnt_q == LAST);
    assign busy      = step_en;
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/booth_negate.sv
module booth_negate #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] value,
    output logic [WIDTH:0]   pos_ext,
    output logic [WIDTH:0]   neg_ext
);
    assign pos_ext = {value[WIDTH-1], value};
    assign neg_ext = ~pos_ext + 1'b1;
endmodule

// File: rtl/booth_step.sv
module booth_step #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] upper,
    input  logic [WIDTH-1:0] lower,
    input  logic [WIDTH:0]   cand_pos,
    input  logic [WIDTH:0]   cand_neg,
    input  logic             cur_bit,
    input  logic             prev_bit,
    output logic [WIDTH-1:0] next_upper,
    output logic [WIDTH-1:0] next_lower
);
    import booth_pkg::*;

    booth_act_e     act;
    logic [WIDTH:0] upper_ext;
    logic [WIDTH:0] sum;

    assign act       = booth_decide(cur_bit, prev_bit);
    assign upper_ext = {upper[WIDTH-1], upper};

    always_comb begin
        case (act)
            ACT_ADD: sum = upper_ext + cand_pos;
            ACT_SUB: sum = upper_ext + cand_neg;
            default: sum = upper_ext;
        endcase
    end

    // Arithmetic right shift of the {upper, lower} pair; sum[WIDTH] is the true sign.
    assign next_upper = sum[WIDTH:1];
    assign next_lower = {sum[0], lower[WIDTH-1:1]};
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult #(
    parameter int WIDTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [WIDTH-1:0]     mcand,
    input  logic [WIDTH-1:0]     mplier,
    output logic                 busy,
    output logic                 done,
    output logic [2*WIDTH-1:0]   product
);
    localparam int PW = 2 * WIDTH;

    logic             load, step_en, last_step;
    logic [WIDTH-1:0] upper_q, lower_q, mreg_q;
    logic             prev_q;
    logic [WIDTH:0]   cand_pos_q, cand_neg_q;
    logic [WIDTH:0]   cand_pos_d, cand_neg_d;
    logic [WIDTH-1:0] upper_d, lower_d;
    logic [PW-1:0]    prod_q;

    booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .load      (load),
        .step_en   (step_en),
        .last_step (last_step),
        .busy      (busy),
        .done      (done)
    );

    booth_negate #(.WIDTH(WIDTH)) u_neg (
        .value   (mcand),
        .pos_ext (cand_pos_d),
        .neg_ext (cand_neg_d)
    );

    booth_step #(.WIDTH(WIDTH)) u_step (
        .upper      (upper_q),
        .lower      (lower_q),
        .cand_pos   (cand_pos_q),
        .cand_neg   (cand_neg_q),
        .cur_bit    (mreg_q[0]),
        .prev_bit   (prev_q),
        .next_upper (upper_d),
        .next_lower (lower_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q    <= '0;
            lower_q    <= '0;
            mreg_q     <= '0;
            prev_q     <= 1'b0;
            cand_pos_q <= '0;
            cand_neg_q <= '0;
            prod_q     <= '0;
        end else if (load) begin
            upper_q    <= '0;
            lower_q    <= '0;
            mreg_q     <= mplier;
            prev_q     <= 1'b0;
            cand_pos_q <= cand_pos_d;
            cand_neg_q <= cand_neg_d;
        end else if (step_en) begin
            upper_q <= upper_d;
            lower_q <= lower_d;
            mreg_q  <= {mreg_q[0], mreg_q[WIDTH-1:1]};
            prev_q  <= mreg_q[0];
            if (last_step) begin
                prod_q <= {upper_d, lower_d};
            end
        end
    end

    assign product = prod_q;

endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
    parameter int WIDTH = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [WIDTH-1:0]   mcand,
    input logic [WIDTH-1:0]   mplier,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);
    localparam int CW = $clog2(WIDTH + 2);

    logic [WIDTH-1:0]          a_q, b_q;
    logic [CW-1:0]             run_cnt;
    logic signed [2*WIDTH-1:0] exp_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            b_q     <= '0;
            run_cnt <= '0;
        end else begin
            if (start && !busy) begin
                a_q <= mcand;
                b_q <= mplier;
            end
            if (busy) run_cnt <= run_cnt + 1'b1;
            else      run_cnt <= '0;
        end
    end

    assign exp_w = $signed(a_q) * $signed(b_q);

    AST_RUN_LENGTH:   assert property (@(posedge clk) disable iff (rst) done |-> run_cnt == CW'(WIDTH)); // R2
    AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (rst) done |=> !done); // R3
    AST_DONE_NO_BUSY: assert property (@(posedge clk) disable iff (rst) !(done && busy)); // R3
    AST_PRODUCT_OK:   assert property (@(posedge clk) disable iff (rst) done |-> product == exp_w); // R4
    AST_PROD_HELD:    assert property (@(posedge clk) disable iff (rst) !$stable(product) |-> done); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst) (busy && run_cnt < CW'(WIDTH - 1)) |=> busy); // R6

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;
    localparam int W  = 4;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [W-1:0]  mcand, mplier;
    logic          busy, done;
    logic [PW-1:0] product;

    int checks = 0;
    int errors = 0;
    logic [PW-1:0] last_prod;

    always #5 clk = ~clk;

    booth_seq_mult #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .product(product)
    );

    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [PW-1:0] sa, sb;
        sa = {{W{a[W-1]}}, a};
        sb = {{W{b[W-1]}}, b};
        return sa * sb;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge with the unit idle or in its done cycle.
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit inject, input bit gap, input string tag);
        int n;
        logic [PW-1:0] exp;
        exp = ref_mul(a, b);
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        check(product == last_prod, "R7 product held while busy", product, last_prod);
        n = 0;
        while (busy && n < 64) begin
            if (inject && n == 1) begin
                mcand = W'($urandom); mplier = W'($urandom); start = 1'b1;
            end else begin
                start = 1'b0;
            end
            check(done == 1'b0, "R3 no done while busy", done, 0);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        check(n == W, "R2 busy length", n, W);
        check(done == 1'b1, "R3 done after busy", done, 1);
        check(product == exp, inject ? "R6 injected start ignored" : tag, product, exp);
        last_prod = exp;
        if (gap) begin
            @(negedge clk);
            check(done == 1'b0, "R3 done single cycle", done, 0);
            check(product == exp, "R7 product held idle", product, exp);
            check(busy == 1'b0, "R3 idle after done", busy, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; start = 1'b0; mcand = '0; mplier = '0;
        last_prod = '0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 reset state", {busy, done, product}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 after reset", {busy, done, product}, 0);

        run(4'b0010, 4'b1100, 1'b0, 1'b1, "R4 2 x -4");
        check(product == 8'hF8, "R4 literal F8", product, 8'hF8);
        run(4'b1000, 4'b1000, 1'b0, 1'b1, "R5 -8 x -8");
        check(product == 8'h40, "R5 literal 64", product, 8'h40);
        run(4'b1000, 4'b0111, 1'b0, 1'b1, "R5 -8 x 7");
        run(4'b0111, 4'b1000, 1'b1, 1'b1, "R5 7 x -8");
        // back-to-back: next start issued in the done cycle
        run(4'b0101, 4'b0011, 1'b0, 1'b0, "R4 5 x 3");
        run(4'b1111, 4'b1001, 1'b0, 1'b0, "R8 back-to-back start");
        run(4'b0110, 4'b1101, 1'b0, 1'b1, "R8 back-to-back second");

        for (int i = 0; i < (1 << (2 * W)); i++) begin
            run(W'(i >> W), W'(i), (i % 7) == 3, (i % 3) == 0, "R4 exhaustive");
        end
        for (int k = 0; k < 40; k++) begin
            run(W'($urandom), W'($urandom), 1'b1, (k % 2) == 0, "R6 random");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule